// File: doc/BRIEF.md
# Multiplexed Host-Port Access Sequencer

This block is a synchronous bus master for the 16-bit multiplexed host port of an external DSP. It runs one read or one write at a time. A request carries a direction, a small port-select address and write data. The sequencer takes the request through five timed phases in a fixed order: address, data setup, data strobe, hold and recovery. While the access runs, it drives chip select, the read/write line, the control-select lines, the data strobe, the outgoing data and the data-bus output enable. When the access finishes, it returns the sampled read data together with a single-cycle done pulse.

The length of each phase comes from a configuration field. A field value N gives a phase of N+1 bus clocks. Values below the minimum for a phase are raised to that minimum. The external device can stall an access with an active-low wait input, but the wait is honoured only in the address and strobe phases. Once the wait is removed, the stalled phase lasts one more clock before it moves on.

The state machine has six states, listed here with the transitions that leave each one:
- `ST_IDLE`: goes to `ST_ADDR` when `req` is high.
- `ST_ADDR`: goes to `ST_SETUP` when the phase count is spent and no stall is in effect.
- `ST_SETUP`: goes to `ST_STRB` when the phase count is spent.
- `ST_STRB`: goes to `ST_HOLD` when the phase count is spent and no stall is in effect. The read data is captured on this transition.
- `ST_HOLD`: goes to `ST_RECOV` when the phase count is spent. The done pulse is raised on this transition.
- `ST_RECOV`: goes to `ST_IDLE` when the phase count is spent.

Every state other than these transitions holds its current state.

Top module: `muxport_seq`

## Requirements
- R1: After reset, the outputs are idle: `cs_n`=1, `ds_n`=1, `rw_n`=1, `bus_oe`=0, `busy`=0 and `done`=0.
- R2: A request is accepted only in the idle state. `req` raised while `busy` is high is ignored, and it neither starts a second access nor alters the running one.
- R3: An accepted access runs the address, setup, strobe, hold and recovery phases in that order. A phase whose field holds N lasts N+1 clocks. The address phase begins in the clock after the edge that accepts `req`.
- R4: Field values below the minimums are clamped. The address field and the setup field are each raised to at least 2, giving 3 clocks. The strobe field is raised to at least 1, giving 2 clocks. The hold and recovery fields have no minimum.
- R5: `cs_n` is low from the first address clock to the last hold clock. `ctl` equals the request address, and `rw_n` equals the inverted write flag (1 = read), from the very clock in which `cs_n` falls, and both stay steady while `cs_n` is low.
- R6: `ds_n` is low exactly during the strobe phase.
- R7: For a write, `bus_oe` is high from the first setup clock through the last hold clock, with `bus_out` equal to the write data. For a read, `bus_oe` is never high.
- R8: For a read, `rd_data` holds the value that `bus_in` carried in the last clock of the strobe phase.
- R9: `done` is a one-clock pulse in the first recovery clock. At that time `rd_data` is already valid.
- R10: `busy` is high from the clock after acceptance until the last recovery clock. The next request is accepted in the first idle clock.
- R11: If `dev_wait_n` is low (stall) during address-phase clocks 0 to W-1, the address phase lasts max(N+1, W+2) clocks.
- R12: If `dev_wait_n` is low during strobe-phase clocks 0 to W-1, the strobe phase lasts max(N+1, W+2) clocks.
- R13: `dev_wait_n` held low during the setup phase or the hold phase does not change any phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | CTL_W | Port-select value driven on `ctl` |
| req_wdata | input | DATA_W | Write data |
| cfg_addr | input | CNT_W | Address phase field (minimum 2) |
| cfg_setup | input | CNT_W | Data setup phase field (minimum 2) |
| cfg_strb | input | CNT_W | Strobe phase field (minimum 1) |
| cfg_hold | input | CNT_W | Hold phase field |
| cfg_recov | input | CNT_W | Recovery phase field |
| dev_wait_n | input | 1 | Device wait, low = stall |
| bus_in | input | DATA_W | Data bus input from the pads |
| cs_n | output | 1 | Chip select, active low |
| rw_n | output | 1 | 1 = read, 0 = write |
| ctl | output | CTL_W | Control-select lines |
| ds_n | output | 1 | Data strobe, active low |
| bus_out | output | DATA_W | Data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-clock completion pulse |
| busy | output | 1 | Access in progress |

## Verification
The bench builds the block with its default parameters: 16 data bits, 2 control-select bits and 4-bit phase fields. The 4-bit fields make it possible to program zero, which shows the clamping of the address, setup and strobe phases. They also allow the maximum value of 15, which gives 16-clock phases everywhere. Stall windows both shorter and longer than the programmed address or strobe length are used, so the max(N+1, W+2) rule is seen from both sides. The capture point is pinned down by changing `bus_in` in every strobe clock except the last.

// File: rtl/muxport_pkg.sv
package muxport_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_SETUP = 3'd2,
        ST_STRB  = 3'd3,
        ST_HOLD  = 3'd4,
        ST_RECOV = 3'd5
    } seq_state_e;

    localparam int NUM_PHASES = 5;

    // Lowest legal field value per phase index (addr, setup, strobe, hold, recovery)
    function automatic int phase_min(input int idx);
        case (idx)
            0: return 2;
            1: return 2;
            2: return 1;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/muxport_min_clamp.sv
module muxport_min_clamp #(
    parameter int W   = 4,
    parameter int MIN = 0
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] val
);
    generate
        if (MIN == 0) begin : g_pass
            assign val = raw;
        end else begin : g_clamp
            localparam logic [W-1:0] MIN_V = W'(MIN);
            assign val = (raw < MIN_V) ? MIN_V : raw;
        end
    endgenerate
endmodule

// File: rtl/muxport_phase_timer.sv
module muxport_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/muxport_seq.sv
module muxport_seq
    import muxport_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CTL_W  = 2,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_write,
    input  logic [CTL_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [CNT_W-1:0]  cfg_addr,
    input  logic [CNT_W-1:0]  cfg_setup,
    input  logic [CNT_W-1:0]  cfg_strb,
    input  logic [CNT_W-1:0]  cfg_hold,
    input  logic [CNT_W-1:0]  cfg_recov,
    input  logic              dev_wait_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic              cs_n,
    output logic              rw_n,
    output logic [CTL_W-1:0]  ctl,
    output logic              ds_n,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);
    seq_state_e state, state_nxt;

    logic [CNT_W-1:0]  cfg_raw [NUM_PHASES];
    logic [CNT_W-1:0]  cfg_eff [NUM_PHASES];
    logic [CNT_W-1:0]  load_val;
    logic              load, expired, stall, adv, wait_q;
    logic              lat_write;
    logic [CTL_W-1:0]  lat_addr;
    logic [DATA_W-1:0] lat_wdata;

    assign cfg_raw[0] = cfg_addr;
    assign cfg_raw[1] = cfg_setup;
    assign cfg_raw[2] = cfg_strb;
    assign cfg_raw[3] = cfg_hold;
    assign cfg_raw[4] = cfg_recov;

    // Per-phase floor on the programmed length
    generate
        for (genvar i = 0; i < NUM_PHASES; i++) begin : g_clamp
            muxport_min_clamp #(.W(CNT_W), .MIN(phase_min(i))) u_clamp (
                .raw (cfg_raw[i]),
                .val (cfg_eff[i])
            );
        end
    endgenerate

    muxport_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    // Wait is honoured in address and strobe phases, plus one clock after release
    assign stall = ((state == ST_ADDR) || (state == ST_STRB)) && (!dev_wait_n || wait_q);
    assign adv   = expired && !stall;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (req) state_nxt = ST_ADDR;
            ST_ADDR:  if (adv) state_nxt = ST_SETUP;
            ST_SETUP: if (adv) state_nxt = ST_STRB;
            ST_STRB:  if (adv) state_nxt = ST_HOLD;
            ST_HOLD:  if (adv) state_nxt = ST_RECOV;
            ST_RECOV: if (adv) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    assign load = (state_nxt != state);

    always_comb begin
        unique case (state_nxt)
            ST_ADDR:  load_val = cfg_eff[0];
            ST_SETUP: load_val = cfg_eff[1];
            ST_STRB:  load_val = cfg_eff[2];
            ST_HOLD:  load_val = cfg_eff[3];
            ST_RECOV: load_val = cfg_eff[4];
            default:  load_val = '0;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Request latch, wait history, read capture and completion pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wait_q    <= 1'b0;
            lat_write <= 1'b0;
            lat_addr  <= '0;
            lat_wdata <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            wait_q <= !dev_wait_n;
            done   <= (state == ST_HOLD) && adv;
            if ((state == ST_IDLE) && req) begin
                lat_write <= req_write;
                lat_addr  <= req_addr;
                lat_wdata <= req_wdata;
            end
            if ((state == ST_STRB) && adv && !lat_write)
                rd_data <= bus_in;
        end
    end

    // Pin outputs decoded from the state
    always_comb begin
        cs_n    = 1'b1;
        ds_n    = 1'b1;
        rw_n    = 1'b1;
        ctl     = '0;
        bus_oe  = 1'b0;
        bus_out = '0;
        busy    = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_ADDR: begin
                cs_n = 1'b0;
                rw_n = !lat_write;
                ctl  = lat_addr;
            end
            ST_SETUP, ST_STRB, ST_HOLD: begin
                cs_n    = 1'b0;
                rw_n    = !lat_write;
                ctl     = lat_addr;
                ds_n    = (state != ST_STRB);
                bus_oe  = lat_write;
                bus_out = lat_write ? lat_wdata : '0;
            end
            ST_RECOV: ;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/muxport_seq_chk.sv
module muxport_seq_chk
    import muxport_pkg::*;
#(
    parameter int CTL_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             dev_wait_n,
    input logic             cs_n,
    input logic             ds_n,
    input logic             rw_n,
    input logic [CTL_W-1:0] ctl,
    input logic             bus_oe,
    input logic             done,
    input logic             busy,
    input seq_state_e       state
);
    p_strobe_inside_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n |-> !cs_n);

    p_oe_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!rw_n && !cs_n));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_ctl_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && $past(!cs_n)) |-> ($stable(ctl) && $stable(rw_n)));

    p_busy_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    p_cs_under_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    p_addr_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_ADDR) && !dev_wait_n) |=> (state == ST_ADDR));

    p_strb_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STRB) && !dev_wait_n) |=> (state == ST_STRB));
endmodule

bind muxport_seq muxport_seq_chk #(.CTL_W(CTL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .dev_wait_n (dev_wait_n),
    .cs_n       (cs_n),
    .ds_n       (ds_n),
    .rw_n       (rw_n),
    .ctl        (ctl),
    .bus_oe     (bus_oe),
    .done       (done),
    .busy       (busy),
    .state      (state)
);

// File: tb/muxport_seq_bench.sv
`timescale 1ns/1ps
module muxport_seq_bench;
    localparam int DATA_W = 16;
    localparam int CTL_W  = 2;
    localparam int CNT_W  = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic              req_write = 1'b0;
    logic [CTL_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic [CNT_W-1:0]  cfg_addr = '0, cfg_setup = '0, cfg_strb = '0, cfg_hold = '0, cfg_recov = '0;
    logic              dev_wait_n = 1'b1;
    logic [DATA_W-1:0] bus_in = '0;
    logic              cs_n, rw_n, ds_n, bus_oe, done, busy;
    logic [CTL_W-1:0]  ctl;
    logic [DATA_W-1:0] bus_out, rd_data;

    int vectors = 0;
    int miscompares = 0;

    always #2 clk = ~clk;

    muxport_seq #(.DATA_W(DATA_W), .CTL_W(CTL_W), .CNT_W(CNT_W)) u_muxport_seq (
        .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .cfg_addr(cfg_addr), .cfg_setup(cfg_setup), .cfg_strb(cfg_strb),
        .cfg_hold(cfg_hold), .cfg_recov(cfg_recov), .dev_wait_n(dev_wait_n), .bus_in(bus_in),
        .cs_n(cs_n), .rw_n(rw_n), .ctl(ctl), .ds_n(ds_n), .bus_out(bus_out), .bus_oe(bus_oe),
        .rd_data(rd_data), .done(done), .busy(busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int eff_len(input int raw, input int mn);
        return ((raw < mn) ? mn : raw) + 1;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // wmode: 0 none, 1 address stall, 2 strobe stall, 3 wait in setup, 4 wait in hold
    task automatic run_access(input bit wr, input logic [CTL_W-1:0] a, input logic [DATA_W-1:0] wd,
                              input logic [DATA_W-1:0] rv, input int wmode, input int wlen,
                              input bit poke_busy, input string tag);
        int e1, e2, e3, e4, e5;
        int n_pre, n_a, n_st, n_h, n_r, n_oe, n_done, guard;
        bit seen_strb, done_first, ctl_ok, data_ok, rd_ok, first_ok;
        e1 = eff_len(int'(cfg_addr), 2);
        e2 = eff_len(int'(cfg_setup), 2);
        e3 = eff_len(int'(cfg_strb), 1);
        e4 = eff_len(int'(cfg_hold), 0);
        e5 = eff_len(int'(cfg_recov), 0);
        if (wmode == 1) e1 = imax(e1, wlen + 2);
        if (wmode == 2) e3 = imax(e3, wlen + 2);
        n_pre = 0; n_a = 0; n_st = 0; n_h = 0; n_r = 0; n_oe = 0; n_done = 0; guard = 0;
        seen_strb = 0; done_first = 0; ctl_ok = 1; data_ok = 1; rd_ok = 1;
        @(negedge clk);
        req = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; bus_in = ~rv;
        @(negedge clk);
        req = 1'b0; req_addr = ~a; req_wdata = ~wd;
        first_ok = !cs_n && busy;
        while (busy && guard < 400) begin
            guard++;
            if (poke_busy && guard == 2) begin
                req = 1'b1; req_write = !wr;
            end else begin
                req = 1'b0;
            end
            dev_wait_n = 1'b1;
            bus_in = ~rv;
            if (!cs_n) begin
                if (ctl != a || rw_n != !wr) ctl_ok = 0;
                if (bus_oe && bus_out != wd) data_ok = 0;
                if (bus_oe) n_oe++;
                if (!ds_n) begin
                    seen_strb = 1;
                    if (wmode == 2 && n_st < wlen) dev_wait_n = 1'b0;
                    if (n_st == e3 - 1) bus_in = rv;
                    n_st++;
                end else if (!seen_strb) begin
                    if (wmode == 1 && !bus_oe && n_pre < wlen) dev_wait_n = 1'b0;
                    if (wmode == 3 && bus_oe) dev_wait_n = 1'b0;
                    if (!bus_oe) n_a++;
                    n_pre++;
                end else begin
                    if (wmode == 4) dev_wait_n = 1'b0;
                    n_h++;
                end
            end else begin
                if (done) begin
                    n_done++;
                    if (n_r == 0) done_first = 1;
                    if (!wr && rd_data != rv) rd_ok = 0;
                end
                n_r++;
            end
            if (done && !cs_n) n_done++;
            @(negedge clk);
        end
        dev_wait_n = 1'b1;
        req = 1'b0;
        check({tag, " R10 busy+cs on first clock"}, int'(first_ok), 1);
        if (wr) begin
            check({tag, " R3 address len"}, n_a, e1);
            check({tag, " R3 setup len"}, n_pre - n_a, e2);
            check({tag, " R7 oe span"}, n_oe, e2 + e3 + e4);
            check({tag, " R7 write data"}, int'(data_ok), 1);
        end else begin
            check({tag, " R3 addr+setup len"}, n_pre, e1 + e2);
            check({tag, " R7 no drive on read"}, n_oe, 0);
            check({tag, " R8 captured data"}, int'(rd_ok), 1);
        end
        check({tag, " R6 strobe len"}, n_st, e3);
        check({tag, " R3 hold len"}, n_h, e4);
        check({tag, " R3 recovery len"}, n_r, e5);
        check({tag, " R5 ctl/rw steady"}, int'(ctl_ok), 1);
        check({tag, " R9 done count"}, n_done, 1);
        check({tag, " R9 done at first recovery"}, int'(done_first), 1);
    endtask

    task automatic set_cfg(input int a, input int s, input int t, input int h, input int r);
        cfg_addr = CNT_W'(a); cfg_setup = CNT_W'(s); cfg_strb = CNT_W'(t);
        cfg_hold = CNT_W'(h); cfg_recov = CNT_W'(r);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 cs_n", int'(cs_n), 1);
        check("R1 ds_n", int'(ds_n), 1);
        check("R1 rw_n", int'(rw_n), 1);
        check("R1 bus_oe", int'(bus_oe), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
    endtask

    task automatic t_read_basic();
        set_cfg(3, 4, 2, 1, 2);
        run_access(1'b0, 2'd2, 16'h0, 16'hA5C3, 0, 0, 0, "read_basic");
    endtask

    task automatic t_write_basic();
        set_cfg(2, 3, 3, 2, 1);
        run_access(1'b1, 2'd1, 16'h5A17, 16'h0, 0, 0, 0, "write_basic");
    endtask

    task automatic t_clamp();
        set_cfg(0, 1, 0, 0, 0);
        run_access(1'b1, 2'd3, 16'hBEEF, 16'h0, 0, 0, 0, "R4 clamp_write");
        run_access(1'b0, 2'd0, 16'h0, 16'h1234, 0, 0, 0, "R4 clamp_read");
    endtask

    task automatic t_max_fields();
        set_cfg(15, 15, 15, 15, 15);
        run_access(1'b0, 2'd1, 16'h0, 16'hFFFE, 0, 0, 0, "max_read");
    endtask

    task automatic t_stall_addr();
        set_cfg(2, 2, 1, 0, 0);
        run_access(1'b1, 2'd2, 16'h0F0F, 16'h0, 1, 8, 0, "R11 addr_long");
        set_cfg(5, 2, 1, 0, 0);
        run_access(1'b1, 2'd2, 16'h1111, 16'h0, 1, 2, 0, "R11 addr_short");
    endtask

    task automatic t_stall_strobe();
        set_cfg(2, 2, 1, 1, 1);
        run_access(1'b0, 2'd3, 16'h0, 16'h7E81, 2, 5, 0, "R12 strb_long_read");
        set_cfg(2, 2, 6, 1, 1);
        run_access(1'b1, 2'd0, 16'hC001, 16'h0, 2, 3, 0, "R12 strb_short_write");
    endtask

    task automatic t_wait_ignored();
        set_cfg(2, 4, 1, 3, 0);
        run_access(1'b1, 2'd1, 16'h2222, 16'h0, 3, 0, 0, "R13 wait_setup");
        run_access(1'b1, 2'd1, 16'h3333, 16'h0, 4, 0, 0, "R13 wait_hold");
    endtask

    task automatic t_busy_ignore();
        int extra_cs;
        set_cfg(2, 2, 1, 0, 1);
        run_access(1'b0, 2'd2, 16'h0, 16'h4C4C, 0, 0, 1, "R2 busy_ignore");
        extra_cs = 0;
        for (int i = 0; i < 12; i++) begin
            if (!cs_n || busy) extra_cs++;
            @(negedge clk);
        end
        check("R2 no second access", extra_cs, 0);
    endtask

    initial begin
        #(4 * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_read_basic();
        t_write_basic();
        t_clamp();
        t_max_fields();
        t_stall_addr();
        t_stall_strobe();
        t_wait_ignored();
        t_busy_ignore();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule